// File: doc/BRIEF.md
# Flag-Based Branch Condition Evaluator

This combinational block decides whether a conditional branch is taken. It subtracts the second operand from the first and keeps only four status flags from that subtraction: negative, overflow, carry and zero. The difference itself is dropped. A 4-bit condition code then picks one test over those flags, and the block drives a single taken bit.

The block also drives a set-less-than word. This word is 1 when the first operand is smaller as a signed value, and 0 otherwise. A processor can pair it with an equal or not-equal branch to build comparisons it does not decode directly. Operand width is a parameter, 32 by default. There is no clock and no state.

Top module: `brcond_eval`

## Requirements
- R1: `flag_n` equals the top bit of `opa - opb` modulo 2^W. `flag_z` is 1 exactly when that difference is zero, that is, when `opa == opb`.
- R2: `flag_c` is the carry out of `opa + ~opb + 1`. It is 1 when `opa >= opb` as unsigned values, meaning no borrow.
- R3: `flag_v` is 1 when the operand signs differ and the sign of the difference differs from the sign of `opa`. This is signed overflow of the subtraction.
- R4: `sel` = 0 (equal) takes when Z=1. `sel` = 1 (not equal) takes when Z=0.
- R5: `sel` = 2 (plus) takes when N=0. `sel` = 3 (minus) takes when N=1.
- R6: `sel` = 4 (carry clear) takes when C=0. `sel` = 5 (carry set) takes when C=1.
- R7: `sel` = 6 (overflow clear) takes when V=0. `sel` = 7 (overflow set) takes when V=1.
- R8: `sel` = 8 (signed less) takes when N xor V = 1. `sel` = 9 (signed less or equal) takes when Z or (N xor V) is 1.
- R9: `sel` = 10 (signed greater or equal) takes when N xor V = 0. `sel` = 11 (signed greater) takes when Z=0 and N xor V = 0.
- R10: `sel` = 12 always takes, whatever the flags are. `sel` = 13, 14 and 15 never take.
- R11: `slt_out` is 1 when `opa < opb` as signed values and 0 otherwise. All of its upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand (minuend) |
| opb | input | W | Second operand (subtrahend) |
| sel | input | 4 | Condition code |
| flag_n | output | 1 | Negative flag of opa - opb |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry (no-borrow) flag |
| flag_z | output | 1 | Zero flag |
| take | output | 1 | Branch taken |
| slt_out | output | W | Signed set-less-than result, 0 or 1 |

## Verification
The bench sweeps every operand pair of a 4-bit instance and every condition code. It also drives a 32-bit instance with the extreme values: the most negative number, the most positive number, all ones, and their neighbours. Expected results come from plain signed and unsigned integer comparisons, never from flag equations.

A design that takes the sign bit of the difference alone as "less than" fails on pairs such as 0x80000000 against 1, where the subtraction overflows. A design that inverts the carry sense (borrow instead of no-borrow) swaps the carry-clear and carry-set results on every unequal pair. A wrong overflow term disturbs the signed codes only when the operand signs differ.

// File: rtl/brcond_eval.sv
module brcond_eval #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   sel,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_c,
  output logic         flag_z,
  output logic         take,
  output logic [W-1:0] slt_out
);
  localparam logic [3:0] C_EQ = 4'd0,  C_NE = 4'd1,  C_PL = 4'd2,  C_MI = 4'd3;
  localparam logic [3:0] C_CC = 4'd4,  C_CS = 4'd5,  C_VC = 4'd6,  C_VS = 4'd7;
  localparam logic [3:0] C_LT = 4'd8,  C_LE = 4'd9,  C_GE = 4'd10, C_GT = 4'd11;
  localparam logic [3:0] C_AL = 4'd12;

  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         lt;

  assign sum  = {1'b0, opa} + {1'b0, ~opb} + {{W{1'b0}}, 1'b1};
  assign diff = sum[W-1:0];

  assign flag_c = sum[W];
  assign flag_n = diff[W-1];
  assign flag_z = (diff == '0);
  assign flag_v = (opa[W-1] ^ opb[W-1]) & (diff[W-1] ^ opa[W-1]);

  assign lt      = flag_n ^ flag_v;
  assign slt_out = {{(W-1){1'b0}}, lt};

  always_comb begin
    case (sel)
      C_EQ:    take = flag_z;
      C_NE:    take = ~flag_z;
      C_PL:    take = ~flag_n;
      C_MI:    take = flag_n;
      C_CC:    take = ~flag_c;
      C_CS:    take = flag_c;
      C_VC:    take = ~flag_v;
      C_VS:    take = flag_v;
      C_LT:    take = lt;
      C_LE:    take = flag_z | lt;
      C_GE:    take = ~lt;
      C_GT:    take = ~flag_z & ~lt;
      C_AL:    take = 1'b1;
      default: take = 1'b0;
    endcase
  end
endmodule

module brcond_eval_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   sel,
  input logic         flag_n,
  input logic         flag_v,
  input logic         flag_c,
  input logic         flag_z,
  input logic         take,
  input logic [W-1:0] slt_out
);
  always_comb begin
    // R1
    zero_flag_chk: assert (flag_z == (opa == opb));
    // R2
    carry_flag_chk: assert (flag_c == (opa >= opb));
    // R11
    slt_word_chk: assert (slt_out == (($signed(opa) < $signed(opb)) ? W'(1) : W'(0)));
    // R8
    lt_take_chk: assert (!(sel == 4'd8) || (take == slt_out[0]));
    // R9
    gt_take_chk: assert (!(sel == 4'd11) || (take == (!flag_z && !slt_out[0])));
    // R10
    always_take_chk: assert (!(sel == 4'd12) || take);
    // R10
    spare_code_chk: assert (!(sel >= 4'd13) || !take);
    // R4
    eq_take_chk: assert (!(sel == 4'd0) || (take == flag_z));
    // R3
    ovf_sign_chk: assert (!(opa[W-1] == opb[W-1]) || !flag_v);
  end
endmodule

bind brcond_eval brcond_eval_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .sel(sel),
  .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
  .take(take), .slt_out(slt_out)
);

// File: tb/sim_brcond_eval.sv
module sim_brcond_eval;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a32, b32, slt32;
  logic [3:0]  a4, b4, slt4, sel;
  logic n32, v32, c32, z32, t32;
  logic n4, v4, c4, z4, t4;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  brcond_eval #(.W(32)) u0 (
    .opa(a32), .opb(b32), .sel(sel),
    .flag_n(n32), .flag_v(v32), .flag_c(c32), .flag_z(z32),
    .take(t32), .slt_out(slt32)
  );

  brcond_eval #(.W(4)) u1 (
    .opa(a4), .opb(b4), .sel(sel),
    .flag_n(n4), .flag_v(v4), .flag_c(c4), .flag_z(z4),
    .take(t4), .slt_out(slt4)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sgn(input longint u, input int w);
    return (u >= (longint'(1) << (w - 1))) ? u - (longint'(1) << w) : u;
  endfunction

  function automatic bit ref_take(input longint ua, input longint ub, input int w, input int code);
    longint sa = sgn(ua, w);
    longint sb = sgn(ub, w);
    longint d  = sa - sb;
    longint dm = (ua - ub) & ((longint'(1) << w) - 1);
    bit neg = dm >= (longint'(1) << (w - 1));
    bit ovf = (d < -(longint'(1) << (w - 1))) || (d > (longint'(1) << (w - 1)) - 1);
    case (code)
      0: return ua == ub;
      1: return ua != ub;
      2: return !neg;
      3: return neg;
      4: return ua < ub;
      5: return ua >= ub;
      6: return !ovf;
      7: return ovf;
      8: return sa < sb;
      9: return sa <= sb;
      10: return sa >= sb;
      11: return sa > sb;
      12: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_pair(input longint ua, input longint ub, input int w,
                            input logic fn, input logic fv, input logic fc, input logic fz,
                            input longint slt);
    longint sa = sgn(ua, w);
    longint sb = sgn(ub, w);
    longint d  = sa - sb;
    longint dm = (ua - ub) & ((longint'(1) << w) - 1);
    chk("R1 flag_n", fn, dm >= (longint'(1) << (w - 1)));
    chk("R1 flag_z", fz, ua == ub);
    chk("R2 flag_c", fc, ua >= ub);
    chk("R3 flag_v", fv, (d < -(longint'(1) << (w - 1))) || (d > (longint'(1) << (w - 1)) - 1));
    chk("R11 slt_out", slt, (sa < sb) ? 1 : 0);
  endtask

  function automatic string req_of(input int code);
    case (code)
      0, 1: return "R4 eq/ne";
      2, 3: return "R5 pl/mi";
      4, 5: return "R6 cc/cs";
      6, 7: return "R7 vc/vs";
      8, 9: return "R8 lt/le";
      10, 11: return "R9 ge/gt";
      default: return "R10 always/spare";
    endcase
  endfunction

  longint corners [8] = '{64'h0, 64'h1, 64'h7FFFFFFF, 64'h80000000,
                          64'hFFFFFFFF, 64'h80000001, 64'h12345678, 64'hFFFFFFFE};

  initial begin
    #4000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    a32 = '0; b32 = '0; a4 = '0; b4 = '0; sel = 4'd0;
    @(negedge clk);
    chk("R1 idle zero flag", z32, 1);
    chk("R4 idle eq take", t32, 1);

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        a4 = 4'(i); b4 = 4'(j); sel = 4'd0;
        #2;
        check_pair(i, j, 4, n4, v4, c4, z4, longint'(slt4));
        for (int s = 0; s < 16; s++) begin
          sel = 4'(s);
          #2;
          chk(req_of(s), t4, ref_take(i, j, 4, s));
        end
      end
      @(negedge clk);
    end

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a32 = 32'(corners[i]); b32 = 32'(corners[j]); sel = 4'd0;
        #2;
        check_pair(corners[i], corners[j], 32, n32, v32, c32, z32, longint'(slt32));
        for (int s = 0; s < 16; s++) begin
          sel = 4'(s);
          #2;
          chk(req_of(s), t32, ref_take(corners[i], corners[j], 32, s));
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule